// File: doc/BRIEF.md
# Processor Power Mode Sequencer

This block governs the operating mode of a processor core. It has three modes: Normal, Idle and Sleep. Software picks a low-power mode by writing a command register. The block then drives four enables. Two are clock enables, one for the CPU and one for the peripherals. Two are power-domain enables, one for the core and one for the peripherals. The real-time clock, the interrupt controller, general purpose I/O and this sequencer are always on and need no enable.

Six wake sources are masked by a software-written enable register: system interrupt, GPIO interrupt, real-time clock interrupt, OS timer interrupt, peripheral interrupt and an external wake pin. An unmasked source that is active while the core is in Idle or Sleep starts a fixed return sequence. Power comes back first. A programmed wait follows, then the CPU clock is enabled, then the sticky status is written, and only then is Normal reported.

Hardware reset is the seventh wake cause. It bypasses the sequence entirely.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset, the block reports the following state.
  - `mode` is 0 (Normal) and all four enables are 1.
  - Status (address 3) reads 0x0040.
  - The wake mask (address 1) reads 0x003F.
  - The wait register (address 2) reads 8.
  - The command register (address 0) reads the current mode code: 0 Normal, 1 Idle, 2 Sleep, 3 waking.
- R2: Writing 1 to address 0 in Normal gives Idle from the next cycle: `mode`=1, `cpu_clk_en`=0, `periph_clk_en`=1, and both power enables 1.
- R3: Writing 2 to address 0 in Normal gives Sleep from the next cycle: `mode`=2 and all four enables 0.
- R4: A low-power mode is entered only on a command write. A command write outside Normal has no effect, and neither has a command value other than 1 or 2.
- R5: Bit i of `wake_src` takes part in waking only when bit i of the wake mask is 1. A masked source leaves Idle or Sleep unchanged.
- R6: The cycle after an enabled source is seen in Idle or Sleep, the wake sequence starts.
  - For W cycles: `mode`=3, both power enables 1, `cpu_clk_en`=0. `periph_clk_en` is 1 if the core came from Idle and 0 if it came from Sleep.
  - Then one cycle with `mode`=3 and all enables 1, then one status-update cycle with `mode`=3 and all enables 1.
  - Then Normal.
- R7: W equals the 16-bit wait register. A value of 0 gives a wait of one cycle.
- R8: Status bits [5:0] are sticky wake causes. Each enabled source that was active in the triggering cycle sets its bit at the status-update cycle. Writing 1 to a status bit clears it. When a clear and a set hit the same bit in the same cycle, the set wins.
- R9: Asserting `rst_n` low at any time forces Normal with all enables 1 at once, with no wait. It sets status bit 6, the reset cause.
- R10: A Sleep command written while an enabled wake source is active is ignored, and the block stays in Normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 command, 1 wake mask, 2 wait count, 3 status |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address, same map |
| rd_data | output | 16 | Read data, combinational from `rd_addr` |
| wake_src | input | 6 | Wake sources, level sensitive, synchronous to `clk` |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| core_pwr_en | output | 1 | Core power-domain enable |
| periph_pwr_en | output | 1 | Peripheral power-domain enable |
| mode | output | 2 | Mode code: 0 Normal, 1 Idle, 2 Sleep, 3 waking |

## Verification
Two functions can fall in the same cycle, and both are provoked deliberately. The first pair is the hardware setting of a wake-cause bit and a software write-1-to-clear of that same bit. The bench chooses a zero wait so that it can count edges exactly, and places the status clear on the status-update cycle. It then judges that the cause bit survives while the other cleared bits are gone. The second pair is a Sleep command and an enabled wake source that are both active at one edge. The bench expects Normal to persist, with every enable still high.

// File: rtl/pms_pkg.sv
package pms_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_IDLE,
    ST_SLEEP,
    ST_WAIT,
    ST_CLKON,
    ST_STAT
  } pms_state_e;

  localparam logic [1:0] MODE_NORMAL = 2'd0;
  localparam logic [1:0] MODE_IDLE   = 2'd1;
  localparam logic [1:0] MODE_SLEEP  = 2'd2;
  localparam logic [1:0] MODE_WAKING = 2'd3;

  localparam logic [1:0] ADDR_CMD    = 2'd0;
  localparam logic [1:0] ADDR_MASK   = 2'd1;
  localparam logic [1:0] ADDR_WAIT   = 2'd2;
  localparam logic [1:0] ADDR_STATUS = 2'd3;

  localparam logic [1:0] CMD_IDLE  = 2'd1;
  localparam logic [1:0] CMD_SLEEP = 2'd2;

  typedef struct packed {
    logic cpu_clk;
    logic periph_clk;
    logic core_pwr;
    logic periph_pwr;
  } pms_en_t;

  function automatic logic [1:0] mode_of(pms_state_e s);
    case (s)
      ST_RUN:   mode_of = MODE_NORMAL;
      ST_IDLE:  mode_of = MODE_IDLE;
      ST_SLEEP: mode_of = MODE_SLEEP;
      default:  mode_of = MODE_WAKING;
    endcase
  endfunction

  function automatic pms_en_t enables_of(pms_state_e s, logic came_from_sleep);
    pms_en_t e;
    e = '{cpu_clk: 1'b1, periph_clk: 1'b1, core_pwr: 1'b1, periph_pwr: 1'b1};
    case (s)
      ST_IDLE:  e.cpu_clk = 1'b0;
      ST_SLEEP: e = '0;
      ST_WAIT: begin
        e.cpu_clk    = 1'b0;
        e.periph_clk = ~came_from_sleep;
      end
      default: ;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/pms_wake_sel.sv
module pms_wake_sel #(
  parameter int NUM_SRC = 6
) (
  input  logic [NUM_SRC-1:0] wake_src,
  input  logic [NUM_SRC-1:0] wake_mask,
  output logic [NUM_SRC-1:0] hit_vec,
  output logic               wake_hit
);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign hit_vec[i] = wake_src[i] & wake_mask[i];
  end

  assign wake_hit = |hit_vec;

endmodule

// File: rtl/pms_regs.sv
module pms_regs
  import pms_pkg::*;
#(
  parameter int                DATA_W   = 16,
  parameter int                NUM_SRC  = 6,
  parameter int                WAIT_W   = 16,
  parameter logic [WAIT_W-1:0] WAIT_RST = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [1:0]         rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  input  logic [1:0]         cur_mode,
  input  logic               stat_set,
  input  logic [NUM_SRC-1:0] stat_cause,
  output logic               req_idle,
  output logic               req_sleep,
  output logic [NUM_SRC-1:0] wake_mask,
  output logic [WAIT_W-1:0]  wait_val
);

  localparam int STAT_W = NUM_SRC + 1;
  localparam logic [STAT_W-1:0] STAT_RST = STAT_W'(1) << NUM_SRC;

  logic [STAT_W-1:0] status;
  logic [STAT_W-1:0] clr_vec;
  logic [STAT_W-1:0] set_vec;

  assign req_idle  = wr_en && (wr_addr == ADDR_CMD) && (wr_data[1:0] == CMD_IDLE);
  assign req_sleep = wr_en && (wr_addr == ADDR_CMD) && (wr_data[1:0] == CMD_SLEEP);

  assign clr_vec = (wr_en && wr_addr == ADDR_STATUS) ? wr_data[STAT_W-1:0] : '0;
  assign set_vec = stat_set ? {1'b0, stat_cause} : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_mask <= '1;
      wait_val  <= WAIT_RST;
      status    <= STAT_RST;
    end else begin
      if (wr_en && wr_addr == ADDR_MASK) wake_mask <= wr_data[NUM_SRC-1:0];
      if (wr_en && wr_addr == ADDR_WAIT) wait_val  <= wr_data[WAIT_W-1:0];
      status <= (status & ~clr_vec) | set_vec;
    end
  end

  always_comb begin
    case (rd_addr)
      ADDR_CMD:  rd_data = DATA_W'(cur_mode);
      ADDR_MASK: rd_data = DATA_W'(wake_mask);
      ADDR_WAIT: rd_data = DATA_W'(wait_val);
      default:   rd_data = DATA_W'(status);
    endcase
  end

  // R8: a cause raised by the sequencer is visible on the next cycle, whatever software cleared
  p_cause_sticks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_set |=> ((status[NUM_SRC-1:0] & $past(stat_cause)) == $past(stat_cause)));

endmodule

// File: rtl/pms_seq.sv
module pms_seq
  import pms_pkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int WAIT_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_idle,
  input  logic               req_sleep,
  input  logic               wake_hit,
  input  logic [NUM_SRC-1:0] hit_vec,
  input  logic [WAIT_W-1:0]  wait_val,
  output pms_state_e         state,
  output logic               from_sleep,
  output logic               stat_set,
  output logic [NUM_SRC-1:0] stat_cause
);

  logic [WAIT_W-1:0] cnt;
  logic              sleep_blocked;
  logic              wake_start;
  logic              wait_done;

  // Wait length in cycles; a programmed zero still costs one cycle.
  function automatic logic [WAIT_W-1:0] wait_len(logic [WAIT_W-1:0] v);
    return (v == '0) ? WAIT_W'(1) : v;
  endfunction

  assign sleep_blocked = req_sleep && wake_hit;
  assign wake_start    = (state == ST_IDLE || state == ST_SLEEP) && wake_hit;
  assign wait_done     = (state == ST_WAIT) && (cnt == WAIT_W'(1));
  assign stat_set      = (state == ST_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_RUN;
      cnt        <= '0;
      from_sleep <= 1'b0;
      stat_cause <= '0;
    end else begin
      case (state)
        ST_RUN: begin
          if (req_sleep && !sleep_blocked) begin
            state      <= ST_SLEEP;
            from_sleep <= 1'b1;
          end else if (req_idle) begin
            state      <= ST_IDLE;
            from_sleep <= 1'b0;
          end
        end
        ST_IDLE, ST_SLEEP: begin
          if (wake_start) begin
            state      <= ST_WAIT;
            cnt        <= wait_len(wait_val);
            stat_cause <= hit_vec;
          end
        end
        ST_WAIT: begin
          if (wait_done) state <= ST_CLKON;
          else           cnt   <= cnt - WAIT_W'(1);
        end
        ST_CLKON: state <= ST_STAT;
        ST_STAT:  state <= ST_RUN;
        default:  state <= ST_RUN;
      endcase
    end
  end

  // R4: Normal is left only on a command
  p_no_auto_lp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && !req_idle && !req_sleep) |=> (state == ST_RUN));

  // R10: sleep command with a live enabled wake keeps Normal
  p_block_sleep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && req_sleep && wake_hit) |=> (state == ST_RUN));

  // R6: an enabled wake in a low-power mode starts the wait
  p_wake_starts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_IDLE || state == ST_SLEEP) && wake_hit) |=> (state == ST_WAIT));

  // R6: the clock stage comes only after the wait, and the status stage after the clock stage
  p_clk_after_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CLKON) |-> ($past(state) == ST_WAIT));
  p_stat_after_clk_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STAT) |-> ($past(state) == ST_CLKON));

  // R7: the wait counter never sits at zero while waiting
  p_cnt_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) |-> (cnt != '0));

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pms_pkg::*;
#(
  parameter int                DATA_W   = 16,
  parameter int                NUM_SRC  = 6,
  parameter int                WAIT_W   = 16,
  parameter logic [WAIT_W-1:0] WAIT_RST = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [1:0]         rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  input  logic [NUM_SRC-1:0] wake_src,
  output logic               cpu_clk_en,
  output logic               periph_clk_en,
  output logic               core_pwr_en,
  output logic               periph_pwr_en,
  output logic [1:0]         mode
);

  pms_state_e         state;
  logic               from_sleep;
  logic               stat_set;
  logic [NUM_SRC-1:0] stat_cause;
  logic               req_idle;
  logic               req_sleep;
  logic [NUM_SRC-1:0] wake_mask;
  logic [WAIT_W-1:0]  wait_val;
  logic [NUM_SRC-1:0] hit_vec;
  logic               wake_hit;
  pms_en_t            en;

  pms_regs #(
    .DATA_W(DATA_W), .NUM_SRC(NUM_SRC), .WAIT_W(WAIT_W), .WAIT_RST(WAIT_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .cur_mode(mode), .stat_set(stat_set), .stat_cause(stat_cause),
    .req_idle(req_idle), .req_sleep(req_sleep),
    .wake_mask(wake_mask), .wait_val(wait_val)
  );

  pms_wake_sel #(.NUM_SRC(NUM_SRC)) u_wake (
    .wake_src(wake_src), .wake_mask(wake_mask),
    .hit_vec(hit_vec), .wake_hit(wake_hit)
  );

  pms_seq #(.NUM_SRC(NUM_SRC), .WAIT_W(WAIT_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_idle(req_idle), .req_sleep(req_sleep),
    .wake_hit(wake_hit), .hit_vec(hit_vec), .wait_val(wait_val),
    .state(state), .from_sleep(from_sleep),
    .stat_set(stat_set), .stat_cause(stat_cause)
  );

  assign en            = enables_of(state, from_sleep);
  assign cpu_clk_en    = en.cpu_clk;
  assign periph_clk_en = en.periph_clk;
  assign core_pwr_en   = en.core_pwr;
  assign periph_pwr_en = en.periph_pwr;
  assign mode          = mode_of(state);

  // R2: Idle keeps power and peripheral clock, stops the CPU clock
  p_idle_outputs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_IDLE) |-> (!cpu_clk_en && periph_clk_en && core_pwr_en && periph_pwr_en));

  // R3: Sleep cuts both domains and both clocks
  p_sleep_outputs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SLEEP) |-> (!core_pwr_en && !periph_pwr_en && !cpu_clk_en && !periph_clk_en));

  // R6: the CPU clock never runs without core power
  p_clk_needs_pwr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en |-> core_pwr_en);

  // R5: a masked source alone never moves a low-power mode
  p_masked_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_IDLE || mode == MODE_SLEEP) && ((wake_src & wake_mask) == '0) && !wr_en)
      |=> $stable(mode));

endmodule

// File: tb/pwr_mode_seq_tb.sv
module pwr_mode_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [5:0]  wake_src = '0;
  logic        cpu_clk_en, periph_clk_en, core_pwr_en, periph_pwr_en;
  logic [1:0]  mode;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  pwr_mode_seq u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .wake_src(wake_src),
    .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
    .core_pwr_en(core_pwr_en), .periph_pwr_en(periph_pwr_en), .mode(mode)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // packed {mode, cpu_clk, periph_clk, core_pwr, periph_pwr}
  function automatic logic [15:0] outs();
    return {10'd0, mode, cpu_clk_en, periph_clk_en, core_pwr_en, periph_pwr_en};
  endfunction

  function automatic logic [15:0] exp_outs(logic [1:0] m, logic c, logic pc, logic cp, logic pp);
    return {10'd0, m, c, pc, cp, pp};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R1", "outputs", outs(), exp_outs(2'd0, 1, 1, 1, 1));
    rd(2'd3, v); check("R1", "status", v, 16'h0040);
    rd(2'd1, v); check("R1", "mask", v, 16'h003F);
    rd(2'd2, v); check("R1", "wait", v, 16'd8);
    rd(2'd0, v); check("R1", "cmd/mode", v, 16'd0);
  endtask

  task automatic t_idle_wake();
    logic [15:0] v;
    wr(2'd3, 16'h007F);
    wr(2'd2, 16'd3);
    wr(2'd0, 16'd1);
    check("R2", "idle outputs", outs(), exp_outs(2'd1, 0, 1, 1, 1));
    for (int i = 0; i < 5; i++) tick();
    check("R4", "idle held without wake", outs(), exp_outs(2'd1, 0, 1, 1, 1));
    wake_src = 6'b001000;
    tick();
    wake_src = '0;
    for (int i = 0; i < 3; i++) begin
      check("R6", "wait from idle", outs(), exp_outs(2'd3, 0, 1, 1, 1));
      tick();
    end
    check("R6", "clock stage", outs(), exp_outs(2'd3, 1, 1, 1, 1));
    tick();
    check("R6", "status stage", outs(), exp_outs(2'd3, 1, 1, 1, 1));
    rd(2'd3, v); check("R8", "status not yet set", v, 16'h0000);
    tick();
    check("R6", "back to normal", outs(), exp_outs(2'd0, 1, 1, 1, 1));
    rd(2'd3, v); check("R8", "cause bit3", v, 16'h0008);
  endtask

  task automatic t_masked_sleep();
    logic [15:0] v;
    wr(2'd3, 16'h007F);
    wr(2'd1, 16'h003E);
    wr(2'd0, 16'd2);
    check("R3", "sleep outputs", outs(), exp_outs(2'd2, 0, 0, 0, 0));
    wake_src = 6'b000001;
    for (int i = 0; i < 10; i++) tick();
    check("R5", "masked source ignored", outs(), exp_outs(2'd2, 0, 0, 0, 0));
    wr(2'd0, 16'd1);
    check("R4", "command outside normal ignored", outs(), exp_outs(2'd2, 0, 0, 0, 0));
    rd(2'd3, v); check("R5", "no status from masked", v, 16'h0000);
    wake_src = 6'b100001;
    tick();
    wake_src = '0;
    check("R6", "wait from sleep", outs(), exp_outs(2'd3, 0, 0, 1, 1));
    for (int i = 0; i < 3; i++) tick();
    check("R6", "wait lasts 3", outs(), exp_outs(2'd3, 1, 1, 1, 1));
    tick(); tick();
    check("R6", "normal after sleep wake", outs(), exp_outs(2'd0, 1, 1, 1, 1));
    rd(2'd3, v); check("R8", "only enabled cause", v, 16'h0020);
    wr(2'd1, 16'h003F);
  endtask

  task automatic t_zero_wait_collision();
    logic [15:0] v;
    wr(2'd2, 16'd0);
    wr(2'd0, 16'd2);
    wake_src = 6'b000010;
    tick();
    wake_src = '0;
    check("R7", "single wait cycle", outs(), exp_outs(2'd3, 0, 0, 1, 1));
    tick();
    check("R7", "clock after one cycle", outs(), exp_outs(2'd3, 1, 1, 1, 1));
    tick();
    // status-update cycle: clear everything in the same cycle
    wr(2'd3, 16'h007F);
    check("R6", "normal after zero wait", outs(), exp_outs(2'd0, 1, 1, 1, 1));
    rd(2'd3, v); check("R8", "set wins over clear", v, 16'h0002);
    wr(2'd3, 16'h0002);
    rd(2'd3, v); check("R8", "write one clears", v, 16'h0000);
  endtask

  task automatic t_blocked_sleep();
    logic [15:0] v;
    wake_src = 6'b010000;
    wr(2'd0, 16'd2);
    check("R10", "sleep blocked", outs(), exp_outs(2'd0, 1, 1, 1, 1));
    tick();
    check("R10", "still normal", outs(), exp_outs(2'd0, 1, 1, 1, 1));
    wake_src = '0;
    wr(2'd0, 16'd3);
    check("R4", "unused command ignored", outs(), exp_outs(2'd0, 1, 1, 1, 1));
    rd(2'd3, v); check("R10", "no status", v, 16'h0000);
  endtask

  task automatic t_reset_in_sleep();
    logic [15:0] v;
    wr(2'd2, 16'd100);
    wr(2'd0, 16'd2);
    check("R3", "sleep before reset", outs(), exp_outs(2'd2, 0, 0, 0, 0));
    #1 rst_n = 1'b0;
    #1;
    check("R9", "reset forces normal", outs(), exp_outs(2'd0, 1, 1, 1, 1));
    rd(2'd3, v); check("R9", "reset cause", v, 16'h0040);
    rd(2'd2, v); check("R9", "wait default back", v, 16'd8);
    tick();
    rst_n = 1'b1;
    tick();
    check("R9", "normal after release", outs(), exp_outs(2'd0, 1, 1, 1, 1));
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_idle_wake();
    t_masked_sleep();
    t_zero_wait_collision();
    t_blocked_sleep();
    t_reset_in_sleep();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule